// File: doc/BRIEF.md
# Serial I/Q Output Formatter

The formatter turns parallel I and Q sample words into serial bit streams for a downstream receiver. A sample-valid strobe delivers each I/Q pair. The block frames the samples as 16-bit words and shifts them out on its serial data pins. It also drives a derived serial clock and a word-start strobe.

There are two modes. In parallel-lane mode, the I word and the Q word leave together on two pins. In sequential mode, the I word and then the Q word leave on the I pin, and each carries a flag bit that marks which one it is. The serial clock is the system clock divided by 1, 2, 4 or 8. At divide-by-1 the clock pin is held high and the receiver runs from the system clock.

Data and strobe change only on the falling edge of the serial clock, so the receiver samples them on the rising edge. A one-deep buffer holds a sample that arrives while a word is still shifting. A sticky flag records any sample that had to be dropped.

Top module: `iq_serial_formatter`

## Requirements
- R1: `div_sel_i` selects the serial period D in system clocks: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8. For D>1, `sclk_o` is low for the first D/2 cycles of each period and high for the rest, and each period starts with a falling edge.
- R2: With `div_sel_i`=0, `sclk_o` is held high.
- R3: Every word is preceded by exactly one serial period in which the strobe is active. During that period both data pins are 0. The strobe is inactive from the first data bit on.
- R4: A serial word is 16 bits. The 10-bit sample sits in bits 15:6, bits 5:1 are 0, and bit 0 is the I-flag.
- R5: In sequential mode (`seq_mode_i`=1), the I word and then the Q word leave on `sd_i_o`, each with its own strobe period. Bit 0 is 1 for the I word and 0 for the Q word. `sd_q_o` stays 0.
- R6: In parallel-lane mode (`seq_mode_i`=0), the I word leaves on `sd_i_o` and the Q word on `sd_q_o` in the same bit periods, under one shared strobe. Bit 0 is 0 in both.
- R7: `msb_first_i`=1 sends bit 15 first. `msb_first_i`=0 sends bit 0 first.
- R8: `strobe_act_hi_i` sets the active strobe level (1 = high). When no strobe period is in progress, `strobe_o` sits at the inactive level.
- R9: A sample that arrives while a word is shifting is held. Its strobe period starts in the serial period right after the last bit of the current frame, with no gap and no overflow.
- R10: A sample that arrives while the buffer is full, and the buffer is not being emptied in that cycle, is dropped and never sent. `overflow_o` then goes to 1 and stays 1 until reset.
- R11: For D>1, the data pins change only on falling edges of `sclk_o`.
- R12: During and after reset, the data pins are 0, `overflow_o` is 0 and the strobe is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample pair valid, one cycle per pair |
| i_data_i | input | 10 | I sample |
| q_data_i | input | 10 | Q sample |
| div_sel_i | input | 2 | Serial clock divide select |
| seq_mode_i | input | 1 | 1 = sequential on one pin, 0 = parallel lanes |
| msb_first_i | input | 1 | 1 = MSB first, 0 = LSB first |
| strobe_act_hi_i | input | 1 | Strobe active level, 1 = high |
| sclk_o | output | 1 | Serial clock |
| strobe_o | output | 1 | Word-start strobe |
| sd_i_o | output | 1 | Serial data, I lane (or both words in sequential mode) |
| sd_q_o | output | 1 | Serial data, Q lane |
| overflow_o | output | 1 | Sticky sample-drop flag |

## Verification
A valid sample enters the buffer at the next edge. Its strobe period begins at the next serial-period boundary, which is one to D cycles later. Because of that variable delay, the bench does not count cycles to the strobe: it polls for the strobe at every falling system-clock edge. Once the strobe is seen, the first bit is due exactly D cycles later and each further bit D cycles after that, so the bench samples in steps of D. A wrong period, a missing strobe period or an extra gap therefore shows up as wrong bits. Back-to-back frames are timed by counting from one strobe to the next: the count must equal 17 serial periods. The overflow flag is checked a few cycles after the sample that was dropped.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  localparam int DIV_SEL_W = 2;
  localparam int DIV_CNT_W = (1 << DIV_SEL_W) - 1;
  typedef enum logic {MODE_PAR = 1'b0, MODE_SEQ = 1'b1} iq_mode_e;
endpackage

// File: rtl/iq_ser_clkdiv.sv
module iq_ser_clkdiv
  import iq_ser_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 tick_o,
  output logic                 sclk_o
);
  logic [DIV_CNT_W-1:0] cnt_q, lim, half;

  assign lim    = ~({DIV_CNT_W{1'b1}} << div_sel_i);
  assign half   = (lim >> 1) + DIV_CNT_W'(1);
  // tick: last cycle of a serial period; sclk falls at the following edge
  assign tick_o = (cnt_q >= lim);
  assign sclk_o = (div_sel_i == '0) || (cnt_q >= half);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_CNT_W'(1);
  end
endmodule

// File: rtl/iq_ser_holdbuf.sv
module iq_ser_holdbuf #(
  parameter int SAMP_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [SAMP_W-1:0] i_i,
  input  logic [SAMP_W-1:0] q_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [SAMP_W-1:0] i_o,
  output logic [SAMP_W-1:0] q_o,
  output logic              overflow_o
);
  logic accept, drop;

  assign accept = valid_i && (!full_o || take_i);
  assign drop   = valid_i && full_o && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o     <= 1'b0;
      i_o        <= '0;
      q_o        <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (accept) begin
        full_o <= 1'b1;
        i_o    <= i_i;
        q_o    <= q_i;
      end else if (take_i) begin
        full_o <= 1'b0;
      end
      if (drop) overflow_o <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_ser_shifter.sv
module iq_ser_shifter
  import iq_ser_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              full_i,
  input  logic [SAMP_W-1:0] hold_i_i,
  input  logic [SAMP_W-1:0] hold_q_i,
  input  logic              seq_mode_i,
  input  logic              msb_first_i,
  output logic              take_o,
  output logic              strobe_slot_o,
  output logic              sd_i_o,
  output logic              sd_q_o
);
  localparam int PAD    = WORD_W - SAMP_W;
  localparam int SLOT_W = $clog2(WORD_W + 1);

  iq_mode_e          mode;
  logic              active_q, sel_q_q, last, data_slot, flag, bit_i, bit_q;
  logic [SLOT_W-1:0] slot_q, pos;
  logic [SAMP_W-1:0] cur_i_q, cur_q_q;
  logic [WORD_W-1:0] word_i, word_q;

  assign mode   = iq_mode_e'(seq_mode_i);
  // slot 0 is the strobe period, slots 1..WORD_W carry data
  assign last   = active_q && (slot_q == SLOT_W'(WORD_W)) && (mode == MODE_PAR || sel_q_q);
  assign take_o = tick_i && full_i && (!active_q || last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      sel_q_q  <= 1'b0;
      slot_q   <= '0;
      cur_i_q  <= '0;
      cur_q_q  <= '0;
    end else if (tick_i) begin
      if (take_o) begin
        active_q <= 1'b1;
        sel_q_q  <= 1'b0;
        slot_q   <= '0;
        cur_i_q  <= hold_i_i;
        cur_q_q  <= hold_q_i;
      end else if (active_q) begin
        if (slot_q == SLOT_W'(WORD_W)) begin
          if (mode == MODE_SEQ && !sel_q_q) begin
            sel_q_q <= 1'b1;
            slot_q  <= '0;
          end else begin
            active_q <= 1'b0;
          end
        end else begin
          slot_q <= slot_q + SLOT_W'(1);
        end
      end
    end
  end

  assign flag   = (mode == MODE_SEQ) && !sel_q_q;
  assign word_i = {cur_i_q, {PAD{1'b0}}} | WORD_W'(flag);
  assign word_q = {cur_q_q, {PAD{1'b0}}};
  assign pos    = msb_first_i ? SLOT_W'(WORD_W) - slot_q : slot_q - SLOT_W'(1);

  always_comb begin
    bit_i = 1'b0;
    bit_q = 1'b0;
    for (int k = 0; k < WORD_W; k++) begin
      if (pos == SLOT_W'(k)) begin
        bit_i = word_i[k];
        bit_q = word_q[k];
      end
    end
  end

  assign data_slot     = active_q && (slot_q != '0);
  assign strobe_slot_o = active_q && (slot_q == '0);
  assign sd_i_o        = data_slot && ((mode == MODE_SEQ && sel_q_q) ? bit_q : bit_i);
  assign sd_q_o        = data_slot && (mode == MODE_PAR) && bit_q;
endmodule

// File: rtl/iq_serial_formatter.sv
module iq_serial_formatter
  import iq_ser_pkg::*;
#(
  parameter int SAMP_W = 10,
  parameter int WORD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [SAMP_W-1:0]    i_data_i,
  input  logic [SAMP_W-1:0]    q_data_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic                 seq_mode_i,
  input  logic                 msb_first_i,
  input  logic                 strobe_act_hi_i,
  output logic                 sclk_o,
  output logic                 strobe_o,
  output logic                 sd_i_o,
  output logic                 sd_q_o,
  output logic                 overflow_o
);
  logic              tick, take, full, strobe_slot;
  logic [SAMP_W-1:0] hold_i, hold_q;

  iq_ser_clkdiv u_div (
    .clk_i, .rst_ni, .div_sel_i,
    .tick_o (tick),
    .sclk_o
  );

  iq_ser_holdbuf #(.SAMP_W(SAMP_W)) u_buf (
    .clk_i, .rst_ni, .valid_i,
    .i_i        (i_data_i),
    .q_i        (q_data_i),
    .take_i     (take),
    .full_o     (full),
    .i_o        (hold_i),
    .q_o        (hold_q),
    .overflow_o
  );

  iq_ser_shifter #(.SAMP_W(SAMP_W), .WORD_W(WORD_W)) u_shf (
    .clk_i, .rst_ni,
    .tick_i        (tick),
    .full_i        (full),
    .hold_i_i      (hold_i),
    .hold_q_i      (hold_q),
    .seq_mode_i, .msb_first_i,
    .take_o        (take),
    .strobe_slot_o (strobe_slot),
    .sd_i_o, .sd_q_o
  );

  assign strobe_o = strobe_act_hi_i ? strobe_slot : !strobe_slot;
endmodule

// File: rtl/iq_serial_formatter_chk.sv
module iq_serial_formatter_chk
  import iq_ser_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DIV_SEL_W-1:0] div_sel_i,
  input logic                 seq_mode_i,
  input logic                 strobe_act_hi_i,
  input logic                 sclk_o,
  input logic                 strobe_o,
  input logic                 sd_i_o,
  input logic                 sd_q_o,
  input logic                 overflow_o
);
  a_r2_sclk_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i == '0) |-> sclk_o);

  a_r3_strobe_one_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i == '0 && strobe_o == strobe_act_hi_i) |=> (strobe_o != strobe_act_hi_i));

  a_r5_q_lane_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_mode_i |-> !sd_q_o);

  a_r10_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r11_change_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i != '0 && $stable(div_sel_i) && !$fell(sclk_o)) |->
      ($stable(sd_i_o) && $stable(sd_q_o)));
endmodule

bind iq_serial_formatter iq_serial_formatter_chk u_chk (.*);

// File: tb/tb_iq_serial_formatter.sv
`timescale 1ns/1ps
module tb_iq_serial_formatter;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [9:0] i_data_i = '0, q_data_i = '0;
  logic [1:0] div_sel_i = '0;
  logic       seq_mode_i = 1'b0, msb_first_i = 1'b1, strobe_act_hi_i = 1'b1;
  logic       sclk_o, strobe_o, sd_i_o, sd_q_o, overflow_o;
  int         errors = 0, checks = 0;

  always #2 clk = ~clk;

  iq_serial_formatter dut (
    .clk_i(clk), .rst_ni, .valid_i, .i_data_i, .q_data_i, .div_sel_i,
    .seq_mode_i, .msb_first_i, .strobe_act_hi_i,
    .sclk_o, .strobe_o, .sd_i_o, .sd_q_o, .overflow_o
  );

  // {seq, msb, div[1:0], pol, i[9:0], q[9:0]}
  localparam logic [24:0] VEC [6] = '{
    {1'b0, 1'b1, 2'd0, 1'b1, 10'h2A5, 10'h15A},
    {1'b0, 1'b0, 2'd1, 1'b0, 10'h3FF, 10'h001},
    {1'b1, 1'b1, 2'd0, 1'b1, 10'h200, 10'h1FF},
    {1'b1, 1'b0, 2'd2, 1'b1, 10'h0F3, 10'h30C},
    {1'b0, 1'b1, 2'd3, 1'b1, 10'h155, 10'h2AA},
    {1'b1, 1'b1, 2'd3, 1'b0, 10'h001, 10'h3FE}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] si, input logic [9:0] sq);
    @(negedge clk);
    valid_i = 1'b1; i_data_i = si; q_data_i = sq;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  // start: 0 = poll for strobe, 1 = strobe due one period later, 2 = already at strobe
  task automatic get_frame(input int d, input logic pol, input int start, input logic msb,
                           output logic [15:0] wi, output logic [15:0] wq, output bit found);
    int n;
    found = 1'b1; wi = '0; wq = '0; n = 0;
    if (start == 0) begin
      while (strobe_o !== pol && n < 3000) begin
        @(negedge clk);
        n++;
      end
    end else if (start == 1) begin
      repeat (d) @(negedge clk);
    end
    if (strobe_o !== pol) begin
      found = 1'b0;
      return;
    end
    chk("R3 data low in strobe period", {30'd0, sd_i_o, sd_q_o}, 32'd0);
    for (int b = 0; b < 16; b++) begin
      repeat (d) @(negedge clk);
      if (b == 0) chk("R3 strobe off at first bit", strobe_o, !pol);
      if (msb) begin
        wi = {wi[14:0], sd_i_o};
        wq = {wq[14:0], sd_q_o};
      end else begin
        wi = {sd_i_o, wi[15:1]};
        wq = {sd_q_o, wq[15:1]};
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] wi, wq;
    bit          found;
    logic [24:0] e;
    int          d, n;

    // R12: state during reset
    repeat (3) @(negedge clk);
    chk("R12 data in reset", {30'd0, sd_i_o, sd_q_o}, 32'd0);
    chk("R12 overflow in reset", overflow_o, 1'b0);
    chk("R12 strobe in reset", strobe_o, 1'b0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 strobe after reset", strobe_o, 1'b0);
    chk("R2 sclk high at div 1", sclk_o, 1'b1);

    // table walk: R4 R5 R6 R7 R8 and R1 via period stepping
    for (int v = 0; v < 6; v++) begin
      e = VEC[v];
      @(negedge clk);
      seq_mode_i = e[24]; msb_first_i = e[23]; div_sel_i = e[22:21]; strobe_act_hi_i = e[20];
      d = 1 << e[22:21];
      repeat (10) @(negedge clk);
      chk("R8 idle strobe level", strobe_o, !e[20]);
      send(e[19:10], e[9:0]);
      get_frame(d, e[20], 0, e[23], wi, wq, found);
      chk("R3 strobe seen", found, 1'b1);
      if (e[24]) begin
        chk("R5 R4 R7 I word with flag", wi, {e[19:10], 5'd0, 1'b1});
        chk("R5 Q lane quiet", wq, 16'd0);
        get_frame(d, e[20], 1, e[23], wi, wq, found);
        chk("R5 strobe before Q word", found, 1'b1);
        chk("R5 R4 R7 Q word", wi, {e[9:0], 6'd0});
        chk("R5 Q lane quiet", wq, 16'd0);
      end else begin
        chk("R6 R4 R7 I lane", wi, {e[19:10], 6'd0});
        chk("R6 R4 R7 Q lane", wq, {e[9:0], 6'd0});
      end
      repeat (20 * d) @(negedge clk);
    end

    // R1 R3 R11: divide by 4 waveform around the strobe period
    @(negedge clk);
    seq_mode_i = 1'b0; msb_first_i = 1'b1; div_sel_i = 2'd2; strobe_act_hi_i = 1'b1;
    repeat (8) @(negedge clk);
    send(10'h3C3, 10'h0F0);
    n = 0;
    while (strobe_o !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R1 sclk low after fall", sclk_o, 1'b0);
    @(negedge clk);
    chk("R1 sclk low second cycle", sclk_o, 1'b0);
    @(negedge clk);
    chk("R1 sclk high at half period", sclk_o, 1'b1);
    chk("R11 data still low mid period", sd_i_o, 1'b0);
    @(negedge clk);
    chk("R3 strobe held whole period", strobe_o, 1'b1);
    @(negedge clk);
    chk("R3 strobe off at first bit", strobe_o, 1'b0);
    chk("R7 first bit is MSB", sd_i_o, 1'b1);
    repeat (100) @(negedge clk);

    // R9: second sample during a frame follows without a gap
    @(negedge clk);
    div_sel_i = 2'd0;
    repeat (4) @(negedge clk);
    send(10'h111, 10'h222);
    n = 0;
    while (strobe_o !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    n = 0;
    send(10'h0AB, 10'h354);
    n = 2;
    while (strobe_o !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk("R9 next strobe exactly 17 periods later", n, 17);
    chk("R9 no overflow with one held sample", overflow_o, 1'b0);
    get_frame(1, 1'b1, 2, 1'b1, wi, wq, found);
    chk("R9 held sample I", wi, {10'h0AB, 6'd0});
    chk("R9 held sample Q", wq, {10'h354, 6'd0});
    repeat (30) @(negedge clk);

    // R10: third sample with buffer full is dropped
    send(10'h001, 10'h002);
    n = 0;
    while (strobe_o !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    send(10'h155, 10'h0AA);
    send(10'h3FF, 10'h3FF);
    @(negedge clk);
    chk("R10 overflow set on drop", overflow_o, 1'b1);
    get_frame(1, 1'b1, 0, 1'b1, wi, wq, found);
    chk("R10 held sample still sent", wi, {10'h155, 6'd0});
    n = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (strobe_o === 1'b1) n++;
    end
    chk("R10 dropped sample never sent", n, 0);
    chk("R10 overflow sticky", overflow_o, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule